// File: doc/BRIEF.md
# Instruction Fetch and Vectored Entry Sequencer

This block is the front end of the instruction cycle for a 16-bit, word-addressed processor. It runs a fixed sequence of register transfers to fetch each instruction. First the address register takes the program counter and the counter advances by one. Next a memory read fills the data register. Last, that word moves into the instruction register. It then hands the instruction to an execution unit and waits until that unit reports the end of the instruction. Memory is reached through a request/ready handshake, so any read latency of one cycle or more is tolerated.

Before every fetch the sequencer checks for a pending interrupt. A software trap instruction and an accepted interrupt share one indirect path. A vector-table address is formed, the routine start address is read from that entry, and it is loaded into the program counter. The return address is written to register 7 at the same time. Trap vectors index a table at 0x0000–0x00FF. Interrupt vectors index a second table at 0x0100–0x01FF.

Top module: `fetch_vec_seq`

## Requirements
- R1: While rst_ni is low, pc_o is 0x3000, ir_o is 0, and mem_req_o, r7_we_o, exec_o and irq_ack_o are all 0.
- R2: A fetch reads memory at the current PC and advances the PC by one. The word read is placed in ir_o. While exec_o is high, ir_o holds that word and pc_o holds the address it was read from plus one.
- R3: A read request holds mem_req_o and mem_addr_o unchanged until mem_rdy_i is sampled high. With a ready latency of L cycles, exec_o first rises L+4 clock edges after reset release when there is no interrupt.
- R4: An interrupt is checked before each fetch. If irq_i is high at that point, the interrupt path runs instead of the fetch, and irq_ack_o pulses high for exactly one cycle.
- R5: A word whose bits [15:12] are 1111 is a trap. Its vector, bits [7:0], is zero-extended to give the table address. Every other value of bits [15:12] goes to execution with no table read.
- R6: A trap writes the address of the word that follows the trap to register 7 (r7_we_o high for one cycle, with r7_wdata_o carrying that address).
- R7: The table address for an accepted interrupt is 0x0100 plus irq_vec_i.
- R8: An accepted interrupt writes the PC value at acceptance to register 7. That value is the address of the next instruction that has not yet been fetched.
- R9: After a trap or an interrupt, the PC takes the word read from the table entry, and the next fetch reads from that address.
- R10: The sequencer stays in execution, with exec_o high and no memory request, until exec_done_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory address (address register) |
| mem_rdata_i | input | 16 | Memory read data |
| mem_rdy_i | input | 1 | Read data valid; ends the request |
| irq_i | input | 1 | Interrupt request level |
| irq_vec_i | input | 8 | Interrupt vector |
| irq_ack_o | output | 1 | One-cycle acceptance pulse |
| exec_o | output | 1 | Instruction in ir_o is being executed |
| exec_done_i | input | 1 | Execution unit finished the instruction |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| mdr_o | output | 16 | Memory data register |
| r7_we_o | output | 1 | Register 7 write enable |
| r7_wdata_o | output | 16 | Return address for register 7 |

## Verification
The bench builds the block with its defaults: 16-bit words, 8-bit vectors, trap table at 0x0000, interrupt table at 0x0100 and reset PC 0x3000. These values make the lowest and highest entries of both tables reachable. Each table entry returns a distinct start address, so a wrong entry shows up in the fetched word. The modelled memory answers after one to four cycles. This exposes the exact cycle count of a fetch, and it shows an interrupt raised during a stalled execution being taken before the next fetch.

// File: rtl/fvs_pkg.sv
package fvs_pkg;

  typedef enum logic [3:0] {
    S_CHK,   // interrupt check before fetch
    S_F1,    // mar <= pc, pc <= pc + 1
    S_F2,    // read into mdr
    S_F3,    // ir <= mdr
    S_DEC,
    S_EXEC,
    S_TRAP,
    S_INT,
    S_VRD,   // read vector entry
    S_VLD    // pc <= entry
  } fvs_state_e;

  typedef struct packed {
    logic ld_mar_pc;
    logic inc_pc;
    logic ld_mar_vec;
    logic vec_int;
    logic ld_mdr;
    logic ld_ir;
    logic ld_pc_mdr;
  } fvs_ctl_t;

endpackage

// File: rtl/fvs_vec_addr.sv
module fvs_vec_addr #(
  parameter int              XW        = 16,
  parameter int              VW        = 8,
  parameter logic [XW-1:0]   TRAP_BASE = '0,
  parameter logic [XW-1:0]   INT_BASE  = 16'h0100
) (
  input  logic          sel_int_i,
  input  logic [VW-1:0] trap_vec_i,
  input  logic [VW-1:0] irq_vec_i,
  output logic [XW-1:0] addr_o
);
  localparam int PAD = XW - VW;

  logic [XW-1:0] trap_a;
  logic [XW-1:0] int_a;

  generate
    if (TRAP_BASE == '0) begin : g_trap_zext
      assign trap_a = {{PAD{1'b0}}, trap_vec_i};
    end else begin : g_trap_off
      assign trap_a = TRAP_BASE + {{PAD{1'b0}}, trap_vec_i};
    end
  endgenerate

  assign int_a  = INT_BASE + {{PAD{1'b0}}, irq_vec_i};
  assign addr_o = sel_int_i ? int_a : trap_a;

endmodule

// File: rtl/fvs_regs.sv
module fvs_regs
  import fvs_pkg::*;
#(
  parameter int            XW       = 16,
  parameter logic [XW-1:0] RESET_PC = 16'h3000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  fvs_ctl_t      ctl_i,
  input  logic [XW-1:0] vaddr_i,
  input  logic [XW-1:0] rdata_i,
  output logic [XW-1:0] pc_o,
  output logic [XW-1:0] mar_o,
  output logic [XW-1:0] mdr_o,
  output logic [XW-1:0] ir_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o  <= RESET_PC;
      mar_o <= '0;
      mdr_o <= '0;
      ir_o  <= '0;
    end else begin
      if (ctl_i.ld_mar_pc)  mar_o <= pc_o;
      if (ctl_i.ld_mar_vec) mar_o <= vaddr_i;
      if (ctl_i.inc_pc)     pc_o  <= pc_o + 1'b1;
      if (ctl_i.ld_pc_mdr)  pc_o  <= mdr_o;
      if (ctl_i.ld_mdr)     mdr_o <= rdata_i;
      if (ctl_i.ld_ir)      ir_o  <= mdr_o;
    end
  end

endmodule

// File: rtl/fvs_ctrl.sv
module fvs_ctrl
  import fvs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_i,
  input  logic       mem_rdy_i,
  input  logic       exec_done_i,
  input  logic       is_trap_i,
  output fvs_ctl_t   ctl_o,
  output fvs_state_e state_o,
  output logic       mem_req_o,
  output logic       r7_we_o,
  output logic       irq_ack_o,
  output logic       exec_o
);

  fvs_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_CHK;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d   = state_q;
    ctl_o     = '0;
    mem_req_o = 1'b0;
    r7_we_o   = 1'b0;
    irq_ack_o = 1'b0;
    exec_o    = 1'b0;
    unique case (state_q)
      S_CHK:  state_d = irq_i ? S_INT : S_F1;
      S_F1: begin
        ctl_o.ld_mar_pc = 1'b1;
        ctl_o.inc_pc    = 1'b1;
        state_d         = S_F2;
      end
      S_F2: begin
        mem_req_o = 1'b1;
        if (mem_rdy_i) begin
          ctl_o.ld_mdr = 1'b1;
          state_d      = S_F3;
        end
      end
      S_F3: begin
        ctl_o.ld_ir = 1'b1;
        state_d     = S_DEC;
      end
      S_DEC:  state_d = is_trap_i ? S_TRAP : S_EXEC;
      S_EXEC: begin
        exec_o = 1'b1;
        if (exec_done_i) state_d = S_CHK;
      end
      S_TRAP: begin
        ctl_o.ld_mar_vec = 1'b1;
        r7_we_o          = 1'b1;
        state_d          = S_VRD;
      end
      S_INT: begin
        ctl_o.ld_mar_vec = 1'b1;
        ctl_o.vec_int    = 1'b1;
        r7_we_o          = 1'b1;
        irq_ack_o        = 1'b1;
        state_d          = S_VRD;
      end
      S_VRD: begin
        mem_req_o = 1'b1;
        if (mem_rdy_i) begin
          ctl_o.ld_mdr = 1'b1;
          state_d      = S_VLD;
        end
      end
      S_VLD: begin
        ctl_o.ld_pc_mdr = 1'b1;
        state_d         = S_CHK;
      end
      default: state_d = S_CHK;
    endcase
  end

  assign state_o = state_q;

  p_ack_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o);

  p_r7_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r7_we_o |=> !r7_we_o);

  p_exec_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && !exec_done_i) |=> (exec_o && !mem_req_o));

endmodule

// File: rtl/fetch_vec_seq.sv
module fetch_vec_seq
  import fvs_pkg::*;
#(
  parameter int              XW        = 16,
  parameter int              VW        = 8,
  parameter logic [3:0]      TRAP_OPC  = 4'hF,
  parameter logic [XW-1:0]   TRAP_BASE = '0,
  parameter logic [XW-1:0]   INT_BASE  = 16'h0100,
  parameter logic [XW-1:0]   RESET_PC  = 16'h3000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          mem_req_o,
  output logic [XW-1:0] mem_addr_o,
  input  logic [XW-1:0] mem_rdata_i,
  input  logic          mem_rdy_i,
  input  logic          irq_i,
  input  logic [VW-1:0] irq_vec_i,
  output logic          irq_ack_o,
  output logic          exec_o,
  input  logic          exec_done_i,
  output logic [XW-1:0] pc_o,
  output logic [XW-1:0] ir_o,
  output logic [XW-1:0] mdr_o,
  output logic          r7_we_o,
  output logic [XW-1:0] r7_wdata_o
);
  localparam int OPC_MSB = XW - 1;
  localparam int OPC_LSB = XW - 4;
  localparam logic [XW:0] TBL_END = {1'b0, INT_BASE} + (1 << VW);

  fvs_ctl_t   ctl;
  fvs_state_e state;
  logic [XW-1:0] vaddr;
  logic          is_trap;

  assign is_trap = (ir_o[OPC_MSB:OPC_LSB] == TRAP_OPC);

  fvs_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_i       (irq_i),
    .mem_rdy_i   (mem_rdy_i),
    .exec_done_i (exec_done_i),
    .is_trap_i   (is_trap),
    .ctl_o       (ctl),
    .state_o     (state),
    .mem_req_o   (mem_req_o),
    .r7_we_o     (r7_we_o),
    .irq_ack_o   (irq_ack_o),
    .exec_o      (exec_o)
  );

  fvs_vec_addr #(
    .XW        (XW),
    .VW        (VW),
    .TRAP_BASE (TRAP_BASE),
    .INT_BASE  (INT_BASE)
  ) u_vec (
    .sel_int_i  (ctl.vec_int),
    .trap_vec_i (ir_o[VW-1:0]),
    .irq_vec_i  (irq_vec_i),
    .addr_o     (vaddr)
  );

  fvs_regs #(
    .XW       (XW),
    .RESET_PC (RESET_PC)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctl_i   (ctl),
    .vaddr_i (vaddr),
    .rdata_i (mem_rdata_i),
    .pc_o    (pc_o),
    .mar_o   (mem_addr_o),
    .mdr_o   (mdr_o),
    .ir_o    (ir_o)
  );

  // return address is the already advanced pc
  assign r7_wdata_o = pc_o;

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_pc_after_mar_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_F1) |=> (pc_o == mem_addr_o + 1'b1));

  p_vec_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && state == S_VRD) |-> ({1'b0, mem_addr_o} < TBL_END));

  p_ack_link_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> (pc_o == $past(r7_wdata_o)));

endmodule

// File: tb/tb_fetch_vec_seq.sv
module tb_fetch_vec_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_rdy, irq_ack, exec_s, exec_done, r7_we;
  logic [15:0] mem_addr, mem_rdata, pc, ir, mdr, r7_wdata;
  logic        irq = 1'b0;
  logic        irq_raise = 1'b0;
  logic [7:0]  irq_vec = 8'h00;
  logic [15:0] prog [16];
  int          lat = 1;
  int          cnt;
  int          n_chk = 0;
  int          n_err = 0;
  int          r7_n, ack_n;
  logic [15:0] r7_cap, va_cap;

  always #5 clk = ~clk;

  fetch_vec_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
    .irq_i(irq), .irq_vec_i(irq_vec), .irq_ack_o(irq_ack),
    .exec_o(exec_s), .exec_done_i(exec_done),
    .pc_o(pc), .ir_o(ir), .mdr_o(mdr),
    .r7_we_o(r7_we), .r7_wdata_o(r7_wdata)
  );

  // memory image: tables point to distinct routines, other words are non-trap
  function automatic logic [15:0] mem_word(input logic [15:0] a);
    if (a < 16'h0100)                       return 16'h4000 + {6'd0, a[7:0], 2'b00};
    else if (a < 16'h0200)                  return 16'h5000 + {4'd0, a[7:0], 4'h0};
    else if (a >= 16'h3000 && a < 16'h3010) return prog[a[3:0]];
    else                                    return 16'h1000 | {4'h0, a[11:0]};
  endfunction

  assign mem_rdata = mem_word(mem_addr);
  assign mem_rdy   = mem_req && (cnt == lat - 1);

  always @(posedge clk or negedge rst_n)
    if (!rst_n)                 cnt <= 0;
    else if (!mem_req || mem_rdy) cnt <= 0;
    else                        cnt <= cnt + 1;

  always @(posedge clk)
    if (irq_ack)        irq <= 1'b0;
    else if (irq_raise) irq <= 1'b1;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r7_n <= 0; ack_n <= 0; r7_cap <= 16'h0; va_cap <= 16'hFFFF;
    end else begin
      if (r7_we) begin r7_n <= r7_n + 1; r7_cap <= r7_wdata; end
      if (irq_ack) ack_n <= ack_n + 1;
      if (mem_req && mem_rdy && mem_addr < 16'h0200) va_cap <= mem_addr;
    end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_exec(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!exec_s && n < 300);
    if (!exec_s) begin n_err++; $display("FAIL timeout waiting for exec actual=0 expected=1"); end
  endtask

  typedef struct packed {
    logic [15:0] instr;
    logic        irq;
    logic [7:0]  vec;
    logic [2:0]  lat;
    logic [15:0] ir;
    logic [15:0] pc;
    logic [15:0] r7;
    logic [1:0]  nw;
    logic [15:0] va;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{16'h1234, 1'b0, 8'h00, 3'd1, 16'h1234, 16'h3001, 16'h0000, 2'd0, 16'hFFFF},
    '{16'hF025, 1'b0, 8'h00, 3'd2, 16'h1094, 16'h4095, 16'h3001, 2'd1, 16'h0025},
    '{16'hF000, 1'b0, 8'h00, 3'd3, 16'h1000, 16'h4001, 16'h3001, 2'd1, 16'h0000},
    '{16'hF0FF, 1'b0, 8'h00, 3'd1, 16'h13FC, 16'h43FD, 16'h3001, 2'd1, 16'h00FF},
    '{16'h1234, 1'b1, 8'h80, 3'd2, 16'h1800, 16'h5801, 16'h3000, 2'd1, 16'h0180},
    '{16'h1234, 1'b1, 8'h00, 3'd1, 16'h1000, 16'h5001, 16'h3000, 2'd1, 16'h0100},
    '{16'h1234, 1'b1, 8'hFF, 3'd3, 16'h1FF0, 16'h5FF1, 16'h3000, 2'd1, 16'h01FF},
    '{16'hE025, 1'b0, 8'h00, 3'd2, 16'hE025, 16'h3001, 16'h0000, 2'd0, 16'hFFFF}
  };

  task automatic start(input logic do_irq);
    rst_n = 1'b0;
    irq_raise = do_irq;
    repeat (2) @(negedge clk);
    irq_raise = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int n, n1, n4;
    vec_t e;
    for (int k = 0; k < 16; k++) prog[k] = 16'h1000 | 16'(k);
    exec_done = 1'b1;

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 pc", pc, 16'h3000);
    chk("R1 ir", ir, 16'h0000);
    chk("R1 idle", {12'h0, mem_req, r7_we, exec_s, irq_ack}, 16'h0000);

    // table walk
    for (int i = 0; i < 8; i++) begin
      e = TBL[i];
      prog[0] = e.instr;
      lat = int'(e.lat);
      irq_vec = e.vec;
      start(e.irq);
      wait_exec(n);
      chk($sformatf("R2 ir entry %0d", i), ir, e.ir);
      chk($sformatf("R9 pc entry %0d", i), pc, e.pc);
      chk($sformatf("R6 r7 writes entry %0d", i), 16'(r7_n), {14'h0, e.nw});
      if (e.nw != 0)
        chk($sformatf("%s r7 value entry %0d", e.irq ? "R8" : "R6", i), r7_cap, e.r7);
      chk($sformatf("%s table addr entry %0d", e.irq ? "R7" : "R5", i), va_cap, e.va);
      chk($sformatf("R4 ack count entry %0d", i), 16'(ack_n), {15'h0, e.irq});
    end

    // R3 latency: exec rises L+4 edges after release
    prog[0] = 16'h1111;
    lat = 1; start(1'b0); wait_exec(n1);
    chk("R3 cycles lat1", 16'(n1), 16'd5);
    lat = 4; start(1'b0); wait_exec(n4);
    chk("R3 cycles lat4", 16'(n4), 16'd8);
    chk("R2 ir after stall", ir, 16'h1111);

    // R2 sequential fetches
    prog[1] = 16'h2222;
    lat = 2; start(1'b0); wait_exec(n);
    chk("R2 first pc", pc, 16'h3001);
    @(negedge clk);
    wait_exec(n);
    chk("R2 second ir", ir, 16'h2222);
    chk("R2 second pc", pc, 16'h3002);

    // R10 hold in execute, then R4/R8 interrupt taken before next fetch
    lat = 1; exec_done = 1'b0; start(1'b0); wait_exec(n);
    repeat (5) @(negedge clk);
    chk("R10 exec held", {15'h0, exec_s}, 16'h0001);
    chk("R10 no request", {15'h0, mem_req}, 16'h0000);
    irq_vec = 8'h10;
    irq_raise = 1'b1;
    @(negedge clk);
    irq_raise = 1'b0;
    exec_done = 1'b1;
    @(negedge clk);
    wait_exec(n);
    chk("R4 ack once", 16'(ack_n), 16'd1);
    chk("R8 r7 next addr", r7_cap, 16'h3001);
    chk("R7 table addr", va_cap, 16'h0110);
    chk("R9 routine ir", ir, 16'h1100);
    chk("R9 routine pc", pc, 16'h5101);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule